// File: doc/BRIEF.md
# SDMA Block Counter and Boundary Tracker

This block tracks the progress of a block-oriented data transfer in an SD host controller data path. A single 32-bit configuration word holds the number of blocks to move, the size of each block in bytes and a code that selects a system-address boundary for the simple DMA engine. After a start pulse, the block counts bytes within the current block and lowers the block count by one each time a block finishes. When the count runs out, it raises a one-cycle completion pulse.

The block also holds the running system address, which moves up by one for every byte. When a byte takes the address onto a multiple of the selected boundary size, the block pauses byte requests and raises a DMA interrupt. The boundary size is 4 KB shifted left by the code, so it ranges from 4 KB up to 512 KB. Software resumes the transfer by writing a new system address. It clears the interrupt status bit by writing 1 to it.

The SD bus, the FIFO and the bus master are outside this block. They appear only as a byte-acknowledge input and the request, status and address outputs.

Top module: `sdma_xfer_tracker`

## Requirements
- R1: After reset, the configuration word reads 0, the system address is 0, and busy_o, done_o, byte_req_o, dma_irq_o and size_err_o are all low.
- R2: The configuration word holds the block count in bits 31:16, the boundary code in bits 14:12 and the block size in bits 11:0. Bit 15 always reads 0. When idle, a write is read back field for field.
- R3: While busy_o is high, writes leave the block count and block size unchanged. The boundary code still takes the written value.
- R4: While a transfer is active, not paused and not finished, byte_req_o is high. Each accepted byte (byte_ack_i high while byte_req_o is high) adds 1 to the system address.
- R5: When block counting is enabled, the accepted byte at position size-1 of a block lowers the block count by exactly 1. The new count is visible on reg_rdata_o[31:16] in the next cycle.
- R6: With counting enabled, the edge that takes the count to 0 drops byte_req_o. At the following edge, busy_o falls and done_o is high for exactly one cycle.
- R7: A start with counting enabled and a count of 0 never raises byte_req_o. done_o pulses on the second edge after the start.
- R8: When bcnt_en_i is low at start, the block count is never lowered. The transfer stays busy across block ends.
- R9: A start with a block size of 0 or above 2048 sets size_err_o and does not start a transfer. A later valid start clears size_err_o.
- R10: When an accepted byte moves the address onto a multiple of 4096 << code, byte_req_o is low from the next cycle on and dma_irq_o is set.
- R11: Writing the system address loads it and clears the pause, so byte_req_o comes back. dma_irq_o stays high until irq_clr_i is pulsed.
- R12: byte_ack_i while byte_req_o is low changes neither the address nor the block count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Configuration word write strobe |
| reg_wdata_i | input | 32 | Configuration word write data |
| reg_rdata_o | output | 32 | Configuration word read data |
| addr_we_i | input | 1 | System address write strobe |
| addr_wdata_i | input | 32 | System address write data |
| sys_addr_o | output | 32 | Running system address |
| bcnt_en_i | input | 1 | Block counting enable, sampled at start |
| start_i | input | 1 | Transfer start pulse |
| byte_ack_i | input | 1 | One byte moved by the data path |
| byte_req_o | output | 1 | Data path may move a byte |
| busy_o | output | 1 | Transfer active |
| done_o | output | 1 | One-cycle transfer completion pulse |
| size_err_o | output | 1 | Last start was refused for an invalid size |
| irq_clr_i | input | 1 | Write-1-to-clear for the DMA interrupt status |
| dma_irq_o | output | 1 | DMA boundary interrupt status |

## Verification
If the byte position is wrong, the count drops on the wrong acknowledge. That shows on reg_rdata_o[31:16] one cycle after the faulty byte. A wrong boundary mask moves the cycle where byte_req_o falls and dma_irq_o rises, and the bench sees this on the edge right after the crossing byte. A finish flag that sets or clears at the wrong time moves the done_o pulse or the fall of busy_o by at least one cycle. The checks look at that exact cycle.

// File: rtl/sdma_xfer_pkg.sv
package sdma_xfer_pkg;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned SIZE_W   = 12;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned MAX_BLK  = 2048;
  localparam int unsigned BND_LOG2 = 12;

  localparam int unsigned SIZE_LSB = 0;
  localparam int unsigned CODE_LSB = SIZE_LSB + SIZE_W;
  localparam int unsigned RSV_BIT  = CODE_LSB + CODE_W;
  localparam int unsigned CNT_LSB  = RSV_BIT + 1;

  typedef struct packed {
    logic [CNT_W-1:0]  bcnt;
    logic              rsv;
    logic [CODE_W-1:0] code;
    logic [SIZE_W-1:0] bsize;
  } cfg_word_t;

  function automatic logic [ADDR_W-1:0] bnd_mask(input logic [CODE_W-1:0] code);
    logic [ADDR_W-1:0] one;
    one = '0;
    one[0] = 1'b1;
    return (one << (BND_LOG2 + int'(code))) - one;
  endfunction
endpackage

// File: rtl/xfer_cfg_reg.sv
module xfer_cfg_reg
  import sdma_xfer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              busy_i,
  input  logic              dec_i,
  output logic [CNT_W-1:0]  bcnt_o,
  output logic [SIZE_W-1:0] bsize_o,
  output logic [CODE_W-1:0] code_o,
  output logic [REG_W-1:0]  rdata_o
);
  cfg_word_t wr;
  logic [CNT_W-1:0]  bcnt_q;
  logic [SIZE_W-1:0] bsize_q;
  logic [CODE_W-1:0] code_q;

  assign wr = cfg_word_t'(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q  <= '0;
      bsize_q <= '0;
      code_q  <= '0;
    end else begin
      if (we_i) code_q <= wr.code;
      if (we_i && !busy_i) begin
        bcnt_q  <= wr.bcnt;
        bsize_q <= wr.bsize;
      end else if (dec_i && bcnt_q != '0) begin
        bcnt_q <= bcnt_q - 1'b1;
      end
    end
  end

  always_comb begin
    cfg_word_t rd;
    rd.bcnt  = bcnt_q;
    rd.rsv   = 1'b0;
    rd.code  = code_q;
    rd.bsize = bsize_q;
    rdata_o  = REG_W'(rd);
  end

  assign bcnt_o  = bcnt_q;
  assign bsize_o = bsize_q;
  assign code_o  = code_q;

  a_r3_size_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(bsize_q));
  a_r5_dec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_i) && bcnt_q != $past(bcnt_q)) |-> (bcnt_q == $past(bcnt_q) - 1'b1));
endmodule

// File: rtl/blk_seq.sv
module blk_seq
  import sdma_xfer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              bcnt_en_i,
  input  logic [CNT_W-1:0]  bcnt_i,
  input  logic [SIZE_W-1:0] bsize_i,
  input  logic              paused_i,
  input  logic              byte_ack_i,
  output logic              byte_req_o,
  output logic              ack_o,
  output logic              dec_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              size_err_o
);
  logic              active_q, cnt_en_q, done_q, err_q;
  logic [SIZE_W-1:0] pos_q;
  logic              finished, size_ok, last_byte;

  assign size_ok    = (bsize_i != '0) && (int'(bsize_i) <= MAX_BLK);
  assign finished   = cnt_en_q && (bcnt_i == '0);
  assign byte_req_o = active_q && !paused_i && !finished;
  assign ack_o      = byte_ack_i && byte_req_o;
  assign last_byte  = (pos_q == bsize_i - 1'b1);
  assign dec_o      = ack_o && last_byte && cnt_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_en_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      pos_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (start_i) begin
          if (size_ok) begin
            err_q    <= 1'b0;
            active_q <= 1'b1;
            cnt_en_q <= bcnt_en_i;
            pos_q    <= '0;
          end else begin
            err_q <= 1'b1;
          end
        end
      end else if (finished) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end else if (ack_o) begin
        pos_q <= last_byte ? '0 : pos_q + 1'b1;
      end
    end
  end

  assign busy_o     = active_q;
  assign done_o     = done_q;
  assign size_err_o = err_q;

  a_r4_no_req_paused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_i |-> !byte_req_o);
  a_r6_done_after_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(active_q) && $past(bcnt_i) == '0 && !busy_o));
  a_r9_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> !active_q);
  a_r5_dec_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_o |-> (active_q && bcnt_i != '0));
endmodule

// File: rtl/bnd_tracker.sv
module bnd_tracker
  import sdma_xfer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              addr_we_i,
  input  logic [ADDR_W-1:0] addr_wdata_i,
  input  logic              ack_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              irq_clr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              paused_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] addr_q, addr_nxt, mask;
  logic              paused_q, irq_q, hit;

  assign mask     = bnd_mask(code_i);
  assign addr_nxt = addr_q + 1'b1;
  assign hit      = ack_i && ((addr_nxt & mask) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      paused_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (addr_we_i) begin
        addr_q   <= addr_wdata_i;
        paused_q <= 1'b0;
      end else if (ack_i) begin
        addr_q <= addr_nxt;
        if (hit) paused_q <= 1'b1;
      end
      if (hit && !addr_we_i) irq_q <= 1'b1;
      else if (irq_clr_i)    irq_q <= 1'b0;
    end
  end

  assign addr_o   = addr_q;
  assign paused_o = paused_q;
  assign irq_o    = irq_q;

  a_r10_pause_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(paused_q) |-> ((addr_q & mask) == '0 && irq_q));
  a_r11_write_resumes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_we_i |=> !paused_q);
  a_r12_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(addr_we_i) && !$past(ack_i)) |-> $stable(addr_q));
endmodule

// File: rtl/sdma_xfer_tracker.sv
module sdma_xfer_tracker
  import sdma_xfer_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        addr_we_i,
  input  logic [31:0] addr_wdata_i,
  output logic [31:0] sys_addr_o,
  input  logic        bcnt_en_i,
  input  logic        start_i,
  input  logic        byte_ack_i,
  output logic        byte_req_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        size_err_o,
  input  logic        irq_clr_i,
  output logic        dma_irq_o
);
  logic [CNT_W-1:0]  bcnt;
  logic [SIZE_W-1:0] bsize;
  logic [CODE_W-1:0] code;
  logic              busy, dec, ack, paused;

  xfer_cfg_reg u_cfg (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .wdata_i(reg_wdata_i), .busy_i(busy), .dec_i(dec),
    .bcnt_o(bcnt), .bsize_o(bsize), .code_o(code), .rdata_o(reg_rdata_o)
  );

  blk_seq u_seq (
    .clk_i, .rst_ni,
    .start_i, .bcnt_en_i, .bcnt_i(bcnt), .bsize_i(bsize), .paused_i(paused),
    .byte_ack_i, .byte_req_o, .ack_o(ack), .dec_o(dec), .busy_o(busy),
    .done_o, .size_err_o
  );

  bnd_tracker u_bnd (
    .clk_i, .rst_ni,
    .addr_we_i, .addr_wdata_i, .ack_i(ack), .code_i(code), .irq_clr_i,
    .addr_o(sys_addr_o), .paused_o(paused), .irq_o(dma_irq_o)
  );

  assign busy_o = busy;

  a_r6_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/sim_sdma_xfer_tracker.sv
module sim_sdma_xfer_tracker;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 0, addr_we = 0, bcnt_en = 0, start = 0, byte_ack = 0, irq_clr = 0;
  logic [31:0] reg_wdata = 0, addr_wdata = 0;
  logic [31:0] reg_rdata, sys_addr;
  logic        byte_req, busy, done, size_err, dma_irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdma_xfer_tracker u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .addr_we_i(addr_we), .addr_wdata_i(addr_wdata), .sys_addr_o(sys_addr),
    .bcnt_en_i(bcnt_en), .start_i(start), .byte_ack_i(byte_ack),
    .byte_req_o(byte_req), .busy_o(busy), .done_o(done), .size_err_o(size_err),
    .irq_clr_i(irq_clr), .dma_irq_o(dma_irq)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg(input logic [15:0] c, input logic [2:0] k, input logic [11:0] s);
    return {c, 1'b0, k, s};
  endfunction

  task automatic wr_cfg(input logic [31:0] v);
    reg_wdata = v; reg_we = 1; step(); reg_we = 0;
  endtask

  task automatic wr_addr(input logic [31:0] v);
    addr_wdata = v; addr_we = 1; step(); addr_we = 0;
  endtask

  task automatic kick(input logic en);
    bcnt_en = en; start = 1; step(); start = 0;
  endtask

  task automatic push(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      check(req, {31'd0, byte_req}, 32'd1);
      byte_ack = 1; step(); byte_ack = 0;
    end
  endtask

  task automatic do_reset();
    rst_n = 0; step(); step(); rst_n = 1; step();
  endtask

  task automatic t_reset();
    check("R1 rdata", reg_rdata, 0);
    check("R1 addr", sys_addr, 0);
    check("R1 outs", {27'd0, busy, done, byte_req, dma_irq, size_err}, 0);
  endtask

  task automatic t_regs();
    wr_cfg(32'hA5C3_FABC);
    check("R2 bit15 zero, fields", reg_rdata, 32'hA5C3_7ABC);
    wr_cfg(cfg(16'd3, 3'd6, 12'h800));
    check("R2 fields", reg_rdata, cfg(16'd3, 3'd6, 12'h800));
  endtask

  task automatic t_main();
    wr_cfg(cfg(16'd3, 3'd0, 12'd4));
    wr_addr(32'h0000_0FF8);
    kick(1'b1);
    check("R4 busy", {31'd0, busy}, 1);
    push(3, "R4 req");
    check("R4 addr step", sys_addr, 32'h0FFB);
    check("R5 no dec mid block", reg_rdata[31:16], 3);
    push(1, "R4 req");
    check("R5 dec", reg_rdata[31:16], 2);
    push(4, "R4 req");
    check("R5 dec2", reg_rdata[31:16], 1);
    check("R10 pause", {31'd0, byte_req}, 0);
    check("R10 irq", {31'd0, dma_irq}, 1);
    check("R10 addr", sys_addr, 32'h1000);
    byte_ack = 1; step(); byte_ack = 0;
    check("R12 addr held", sys_addr, 32'h1000);
    check("R12 count held", reg_rdata[31:16], 1);
    wr_addr(32'h0000_2000);
    check("R11 resume", {31'd0, byte_req}, 1);
    check("R11 irq held", {31'd0, dma_irq}, 1);
    irq_clr = 1; step(); irq_clr = 0;
    check("R11 irq cleared", {31'd0, dma_irq}, 0);
    wr_cfg(cfg(16'd9, 3'd5, 12'h010));
    check("R3 ignored while busy", reg_rdata, cfg(16'd1, 3'd5, 12'd4));
    push(4, "R4 req");
    check("R6 count zero", reg_rdata[31:16], 0);
    check("R6 req low", {31'd0, byte_req}, 0);
    check("R6 no done yet", {30'd0, busy, done}, 2'b10);
    step();
    check("R6 done", {30'd0, busy, done}, 2'b01);
    step();
    check("R6 done one cycle", {31'd0, done}, 0);
    check("R10 no pause on 128K", sys_addr, 32'h2004);
  endtask

  task automatic t_zero();
    wr_cfg(cfg(16'd0, 3'd0, 12'd4));
    kick(1'b1);
    check("R7 no req", {29'd0, busy, byte_req, done}, 3'b100);
    step();
    check("R7 done", {30'd0, busy, done}, 2'b01);
  endtask

  task automatic t_noen();
    wr_cfg(cfg(16'd5, 3'd0, 12'd2));
    kick(1'b0);
    push(6, "R8 req");
    check("R8 count kept", reg_rdata[31:16], 5);
    check("R8 busy", {31'd0, busy}, 1);
    do_reset();
  endtask

  task automatic t_bad();
    wr_cfg(cfg(16'd1, 3'd0, 12'h801));
    kick(1'b1);
    check("R9 err big", {30'd0, busy, size_err}, 2'b01);
    wr_cfg(cfg(16'd1, 3'd0, 12'h000));
    kick(1'b1);
    check("R9 err zero", {30'd0, busy, size_err}, 2'b01);
    wr_cfg(cfg(16'd0, 3'd0, 12'h800));
    kick(1'b1);
    check("R9 err cleared", {30'd0, busy, size_err}, 2'b10);
    step();
  endtask

  initial begin
    fork
      begin
        do_reset();
        t_reset();
        t_regs();
        t_main();
        t_zero();
        t_noen();
        t_bad();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule